// File: doc/BRIEF.md
# Reloading Interval Timer Bank

This block holds a bank of down-counting interval timers behind a word-addressed register port. Each timer has a base count word and a current count word. The top bit of the base word is a count-inhibit flag. A write that clears this flag starts the timer from the written value. While the timer runs, it steps down once on every cycle in which `tick_en` is high. When the count expires, the timer reloads from the base word, inverts a toggle bit held in the top bit of the current count word, and raises a one-cycle pulse on its own bit of `irq_pulse`.

Each timer also keeps a vector/priority word and a destination word. These are plain storage for whatever routing logic sits downstream, and the block does not act on them. One shared frequency word at offset 0 is also plain read/write storage. Reads are registered: `rd_valid` and `rdata` appear in the cycle after `rd_en`, and they show the state as it was before that clock edge.

Top module: `ivt_bank`

## Requirements
- R1: After reset, every current count word reads 0x0000_0000, every base count word reads 0x8000_0000 (inhibit set), the frequency word reads 0, and no pulse is issued.
- R2: While bit 31 of a timer's base word is 1, `tick_en` leaves its current count unchanged, even after a base write that keeps bit 31 set.
- R3: A base write that changes bit 31 from 1 to 0 loads bits 30:0 of the current count with the written bits 30:0 and clears the toggle bit (bit 31 of the current count).
- R4: A running timer decrements its count by one on each clock edge where `tick_en` is 1, and holds its count when `tick_en` is 0.
- R5: On an edge where `tick_en` is 1 and a running timer's count is 1, the count reloads from base bits 30:0, the toggle bit inverts, and that timer's `irq_pulse` bit is high for exactly the next cycle. The period is therefore B ticks for a base value B.
- R6: A base write that changes bit 31 from 0 to 1 stops the timer. Bits 30:0 of the current count become 0 and the toggle bit is kept.
- R7: A start with value 0 (bit 31 cleared, bits 30:0 zero), or a reload from a zero base, leaves the timer stopped. Its current count then reads as held, and it issues no pulse.
- R8: A read of the current count returns the toggle bit in bit 31 and the remaining count in bits 30:0. `rd_valid` and `rdata` follow `rd_en` by one cycle.
- R9: The frequency word is at byte offset 0x000. Timer n occupies offsets 0x10+0x40*n (current count), +0x10 (base), +0x20 (vector/priority) and +0x30 (destination). The vector, destination and frequency words read back what was written. Writes to the current count word are ignored.
- R10: An access whose address has any of bits 3:0 set has no effect, and such a read returns 0xFFFF_FFFF. An aligned read outside the map also returns 0xFFFF_FFFF.
- R11: If a base write lands on the same edge as an expiry, the reload takes the newly written bits 30:0. If that write sets bit 31, the stop wins: no pulse is issued, the toggle bit is kept and the count becomes 0.
- R12: A base write that leaves bit 31 clear does not disturb the running count. The new value is used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count step enable shared by all timers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High the cycle after `rd_en` |
| irq_pulse | output | NUM_TMR | One-cycle expiry pulse, one bit per timer |

## Verification
A write to the base word can land on the same clock edge as that timer's expiry tick. Two outcomes then compete: the reload from the base word and the write to it. The bench first runs a timer down to a count of 1. It then raises `tick_en` and `wr_en` together in one cycle, once with a new value that keeps bit 31 clear and once with bit 31 set. In the first case a pulse must appear and the next read must show the inverted toggle with the new value. In the second case no pulse may appear and the read must show the kept toggle with a zero count.

// File: rtl/ivt_bank_pkg.sv
package ivt_bank_pkg;

  typedef enum logic [1:0] {
    REG_CUR  = 2'd0,
    REG_BASE = 2'd1,
    REG_VEC  = 2'd2,
    REG_DEST = 2'd3
  } tmr_reg_e;

  localparam int TMR_FIRST  = 16;
  localparam int TMR_STRIDE = 64;
  localparam int REG_STRIDE = 16;

endpackage

// File: rtl/ivt_addr_dec.sv
module ivt_addr_dec
  import ivt_bank_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int NUM_TMR = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              aligned,
  output logic              hit_freq,
  output logic              hit_tmr,
  output logic [IDX_W-1:0]  tmr_idx,
  output tmr_reg_e          reg_sel
);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(TMR_FIRST);
  localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(NUM_TMR * TMR_STRIDE);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel      = addr - FIRST_A;
    aligned  = (rel[3:0] == 4'd0);
    hit_freq = (addr == '0);
    hit_tmr  = (addr >= FIRST_A) && (rel < SPAN_A);
    tmr_idx  = rel[6 +: IDX_W];
    reg_sel  = tmr_reg_e'(rel[5:4]);
  end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              sel_wr,
  input  tmr_reg_e          reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cur_word,
  output logic [DATA_W-1:0] base_word,
  output logic [DATA_W-1:0] vec_word,
  output logic [DATA_W-1:0] dest_word,
  output logic              irq
);
  localparam int CNT_W = DATA_W - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic              tog_q;
  logic              run_q;
  logic              irq_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] dest_q;

  logic             base_wr;
  logic             inh_clr;
  logic             inh_set;
  logic             expire;
  logic [CNT_W-1:0] reload_val;

  always_comb begin
    base_wr    = sel_wr && (reg_sel == REG_BASE);
    inh_clr    = base_wr &&  base_q[DATA_W-1] && !wdata[DATA_W-1];
    inh_set    = base_wr && !base_q[DATA_W-1] &&  wdata[DATA_W-1];
    expire     = run_q && tick_en && (cnt_q == CNT_W'(1));
    reload_val = base_wr ? wdata[CNT_W-1:0] : base_q[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= {1'b1, {CNT_W{1'b0}}};
      vec_q  <= '0;
      dest_q <= '0;
    end else if (sel_wr) begin
      case (reg_sel)
        REG_BASE: base_q <= wdata;
        REG_VEC:  vec_q  <= wdata;
        REG_DEST: dest_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (inh_set) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (inh_clr) begin
        cnt_q <= wdata[CNT_W-1:0];
        tog_q <= 1'b0;
        run_q <= (wdata[CNT_W-1:0] != '0);
      end else if (expire) begin
        cnt_q <= reload_val;
        tog_q <= ~tog_q;
        irq_q <= 1'b1;
        run_q <= (reload_val != '0);
      end else if (run_q && tick_en) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cur_word  = {tog_q, cnt_q};
  assign base_word = base_q;
  assign vec_word  = vec_q;
  assign dest_word = dest_q;
  assign irq       = irq_q;

  assert_pulse_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(run_q && tick_en));
  assert_toggle_on_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (tog_q != $past(tog_q)));
  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !base_wr) |=> ($stable(cnt_q) && $stable(tog_q)));
  assert_run_not_inhibited_R6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> !base_q[DATA_W-1]);
  assert_run_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

endmodule

// File: rtl/ivt_bank.sv
module ivt_bank
  import ivt_bank_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               rd_valid,
  output logic [NUM_TMR-1:0] irq_pulse
);
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

  logic             aligned;
  logic             hit_freq;
  logic             hit_tmr;
  logic [IDX_W-1:0] tmr_idx;
  tmr_reg_e         reg_sel;

  logic [DATA_W-1:0] freq_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rd_mux;

  logic [DATA_W-1:0] cur_w  [NUM_TMR];
  logic [DATA_W-1:0] base_w [NUM_TMR];
  logic [DATA_W-1:0] vec_w  [NUM_TMR];
  logic [DATA_W-1:0] dest_w [NUM_TMR];

  ivt_addr_dec #(
    .ADDR_W (ADDR_W),
    .NUM_TMR(NUM_TMR),
    .IDX_W  (IDX_W)
  ) u_dec (
    .addr    (addr),
    .aligned (aligned),
    .hit_freq(hit_freq),
    .hit_tmr (hit_tmr),
    .tmr_idx (tmr_idx),
    .reg_sel (reg_sel)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    logic sel_wr;
    assign sel_wr = wr_en && aligned && hit_tmr && (tmr_idx == IDX_W'(g));
    ivt_channel #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .sel_wr   (sel_wr),
      .reg_sel  (reg_sel),
      .wdata    (wdata),
      .cur_word (cur_w[g]),
      .base_word(base_w[g]),
      .vec_word (vec_w[g]),
      .dest_word(dest_w[g]),
      .irq      (irq_pulse[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
    end else if (wr_en && aligned && hit_freq) begin
      freq_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '1;
    if (aligned) begin
      if (hit_freq) begin
        rd_mux = freq_q;
      end else if (hit_tmr) begin
        case (reg_sel)
          REG_CUR:  rd_mux = cur_w[tmr_idx];
          REG_BASE: rd_mux = base_w[tmr_idx];
          REG_VEC:  rd_mux = vec_w[tmr_idx];
          default:  rd_mux = dest_w[tmr_idx];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_unaligned_ones_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr[3:0] != 4'd0)) |=> (rdata == '1));
  assert_freq_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == '0)) |=> $stable(freq_q));

endmodule

// File: tb/ivt_bank_bench.sv
module ivt_bank_bench;
  localparam int NT = 4;
  localparam int AW = 9;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rd_valid;
  logic [NT-1:0] irq_pulse;

  int errors = 0;
  int checks = 0;
  int pulses [NT];
  bit done = 0;

  always #2 clk = ~clk;

  ivt_bank #(.NUM_TMR(NT), .ADDR_W(AW), .DATA_W(DW)) u_ivt_bank (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .irq_pulse(irq_pulse)
  );

  initial for (int i = 0; i < NT; i++) pulses[i] = 0;

  always @(negedge clk) begin
    if (!rst) for (int i = 0; i < NT; i++) if (irq_pulse[i]) pulses[i]++;
  end

  function automatic logic [AW-1:0] a_cur(int n);  return AW'(16 + 64*n); endfunction
  function automatic logic [AW-1:0] a_base(int n); return AW'(32 + 64*n); endfunction
  function automatic logic [AW-1:0] a_vec(int n);  return AW'(48 + 64*n); endfunction
  function automatic logic [AW-1:0] a_dest(int n); return AW'(64 + 64*n); endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    checks++;
    if (rd_valid !== 1'b1) begin
      errors++;
      $display("FAIL R8: rd_valid actual=%0b expected=1", rd_valid);
    end
  endtask

  task automatic tick(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    #1;
  endtask

  task automatic test_reset();
    logic [DW-1:0] d;
    for (int n = 0; n < NT; n++) begin
      rd(a_cur(n), d);  check("R1 cur", d, 32'h0);
      rd(a_base(n), d); check("R1 base", d, 32'h8000_0000);
    end
    rd(AW'(0), d); check("R1 freq", d, 32'h0);
    check("R1 pulses", 32'(pulses[0] + pulses[1] + pulses[2] + pulses[3]), 32'd0);
  endtask

  task automatic test_inhibit_hold();
    logic [DW-1:0] d;
    tick(10);
    rd(a_cur(0), d); check("R2 idle", d, 32'h0);
    wr(a_base(0), 32'h8000_0009);
    tick(5);
    rd(a_cur(0), d);  check("R2 inhibited", d, 32'h0);
    rd(a_base(0), d); check("R2 base", d, 32'h8000_0009);
  endtask

  task automatic test_count();
    logic [DW-1:0] d;
    wr(a_base(0), 32'h0000_0005);
    rd(a_cur(0), d); check("R3 load", d, 32'h5);
    tick(3);
    rd(a_cur(0), d); check("R4 count", d, 32'h2);
    repeat (4) @(negedge clk);
    rd(a_cur(0), d); check("R4 hold", d, 32'h2);
    tick(1);
    check("R5 no early pulse", 32'(pulses[0]), 32'd0);
    tick(1);
    check("R5 pulse", 32'(pulses[0]), 32'd1);
    rd(a_cur(0), d); check("R5 reload toggle", d, 32'h8000_0005);
    tick(5);
    check("R5 period", 32'(pulses[0]), 32'd2);
    rd(a_cur(0), d); check("R5 toggle back", d, 32'h0000_0005);
  endtask

  task automatic test_stop();
    logic [DW-1:0] d;
    tick(5);
    check("R6 pulse before stop", 32'(pulses[0]), 32'd3);
    wr(a_base(0), 32'h8000_0005);
    rd(a_cur(0), d); check("R6 stop keeps toggle", d, 32'h8000_0000);
    tick(6);
    rd(a_cur(0), d); check("R6 stays stopped", d, 32'h8000_0000);
    check("R6 no pulse", 32'(pulses[0]), 32'd3);
  endtask

  task automatic test_zero();
    logic [DW-1:0] d;
    wr(a_base(3), 32'h0);
    rd(a_cur(3), d); check("R7 zero start", d, 32'h0);
    tick(6);
    rd(a_cur(3), d); check("R7 zero held", d, 32'h0);
    check("R7 no pulse", 32'(pulses[3]), 32'd0);
  endtask

  task automatic test_map();
    logic [DW-1:0] d;
    wr(AW'(0), 32'h1234_5678);
    rd(AW'(0), d); check("R9 freq", d, 32'h1234_5678);
    wr(a_vec(1), 32'hA5A5_0001);
    rd(a_vec(1), d); check("R9 vec t1", d, 32'hA5A5_0001);
    wr(a_dest(2), 32'h0000_0003);
    rd(a_dest(2), d); check("R9 dest t2", d, 32'h0000_0003);
    rd(a_vec(2), d); check("R9 vec t2 untouched", d, 32'h0);
    wr(a_cur(3), 32'h0000_0042);
    rd(a_cur(3), d); check("R9 cur write ignored", d, 32'h0);
    rd(a_base(3), d); check("R9 base t3", d, 32'h0);
  endtask

  task automatic test_unaligned();
    logic [DW-1:0] d;
    wr(a_base(1) + AW'(4), 32'h0000_0003);
    rd(a_base(1), d); check("R10 ignored write", d, 32'h8000_0000);
    tick(4);
    check("R10 no start", 32'(pulses[1]), 32'd0);
    rd(a_base(1) + AW'(4), d); check("R10 unaligned read", d, 32'hFFFF_FFFF);
    rd(AW'(9'h1F0), d); check("R10 unmapped read", d, 32'hFFFF_FFFF);
  endtask

  task automatic test_rewrite();
    logic [DW-1:0] d;
    wr(a_base(2), 32'd10);
    tick(2);
    rd(a_cur(2), d); check("R12 running", d, 32'd8);
    wr(a_base(2), 32'd3);
    rd(a_cur(2), d); check("R12 count kept", d, 32'd8);
    tick(7);
    check("R12 no pulse yet", 32'(pulses[2]), 32'd0);
    tick(1);
    check("R12 pulse", 32'(pulses[2]), 32'd1);
    rd(a_cur(2), d); check("R12 new reload", d, 32'h8000_0003);
  endtask

  task automatic test_collide();
    logic [DW-1:0] d;
    wr(a_base(1), 32'd4);
    tick(3);
    rd(a_cur(1), d); check("R11 at one", d, 32'd1);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = a_base(1); wdata = 32'd7;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    #1;
    check("R11 pulse with write", 32'(pulses[1]), 32'd1);
    rd(a_cur(1), d); check("R11 reload uses new", d, 32'h8000_0007);
    tick(6);
    rd(a_cur(1), d); check("R11 at one again", d, 32'h8000_0001);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = a_base(1); wdata = 32'h8000_0007;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    #1;
    check("R11 stop wins", 32'(pulses[1]), 32'd1);
    rd(a_cur(1), d); check("R11 stopped value", d, 32'h8000_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_inhibit_hold();
    test_count();
    test_stop();
    test_zero();
    test_map();
    test_unaligned();
    test_rewrite();
    test_collide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule